// File: doc/BRIEF.md
# Miss-Dependent Drain and Replay Buffer

This scheduler-side block holds instructions that wait on outstanding data-cache misses. Every dispatched instruction lands in a small array of reservation-station slots. An instruction with no outstanding miss is ready at once. It leaves through the issue output and frees its slot. An instruction that depends on a miss keeps its slot, tagged with the miss it waits for, for as long as the array still has room.

When the array is full and a dispatch is blocked, one waiting instruction per cycle drains into a larger waiting buffer. That buffer is a single-ported memory. The drain needs no pseudo-execution or commit step. A miss-fill completion releases its tag. Waiting slots in the array with that tag become ready. Buffered entries with that tag are read back one at a time, oldest first, and put back into the array as ready instructions.

One port controller shares the buffer's single port between drain writes and replay reads. It is a two-state machine:
- **PORT_IDLE**: the port is free. Transition *launch read* goes to PORT_RETURN when a released entry exists and the array has a free slot. Transition *stay idle* keeps PORT_IDLE, with or without a drain write in that cycle.
- **PORT_RETURN**: the read data arrives and is inserted into the array. Transition *insert done* always returns to PORT_IDLE.

Top module: `missq_replay`

## Requirements
- R1: An entry that is not waiting is ready. The lowest-index ready slot is driven on `iss_valid`/`iss_pay` combinationally from stored state, at most one per cycle, and its slot is free at the next edge. An entry dispatched ready at edge N is visible on issue after edge N.
- R2: A dispatched entry with `disp_dep`=1 waits in its slot and does not issue. A fill whose tag equals the slot's tag makes it ready from the next cycle. A dispatch that meets a same-tag fill in its own cycle enters as ready.
- R3: `rs_full` is high when every slot is occupied. `disp_stall` is high when `rs_full` is high, in a cycle that launches a replay read, and in the cycle that returns one. A dispatch is accepted only when `disp_valid`=1 and `disp_stall`=0, and it goes into the lowest-index free slot.
- R4: A drain writes one entry to the buffer in a cycle when all of the following hold: the array is full, `disp_valid` is high, the port is idle, no read is launched and the buffer is not full. The drained entry is the lowest-index waiting slot whose tag does not match a same-cycle fill. Its slot is free after that edge.
- R5: `wb_full` is high when the buffer holds WB_DEPTH entries. While it is high, no drain happens and `disp_stall` stays high until a replay frees space.
- R6: A fill releases its tag only if the buffer holds an entry with that tag after the cycle. A replay read is launched from PORT_IDLE when a released entry exists and a slot is free. The port performs at most one read or one write per cycle.
- R7: A replayed entry is inserted as ready into the lowest free slot one cycle after its read. Dispatch is stalled in both the read and the return cycle, so replays come at most every second cycle.
- R8: A fill for a tag with no buffered entry is ignored by the buffer. Entries of that tag drained later stay until a new fill for the tag arrives.
- R9: After reset, no slot and no buffer entry is occupied: `iss_valid`, `disp_stall`, `rs_full` and `wb_full` are all 0.
- R10: Replay reads take the oldest released buffered entry first. Entries of one tag therefore come back, and issue, in the order they were drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dep | input | 1 | Dispatched instruction waits on a miss |
| disp_tag | input | TAG_W | Miss tag of the dispatched instruction |
| disp_pay | input | PAY_W | Opaque instruction payload |
| disp_stall | output | 1 | Dispatch is blocked this cycle |
| iss_valid | output | 1 | A ready entry issues this cycle |
| iss_pay | output | PAY_W | Payload of the issuing entry |
| fill_valid | input | 1 | Miss-fill completion |
| fill_tag | input | TAG_W | Tag of the completed miss |
| rs_full | output | 1 | All reservation-station slots occupied |
| wb_full | output | 1 | Waiting buffer holds WB_DEPTH entries |

## Verification
Two events can fall in the same cycle:
- A miss-fill can arrive in the very cycle a drain picks a waiting slot of the same tag.
- A fill can arrive in the cycle a dependent instruction with that tag is dispatched.

The random phase provokes both by keeping the array full under steady dependent dispatch while fills hit random tags. A bench model decides each case from the requirements: the same-tag slot must be skipped by the drain and woken, and the dispatched entry must enter as ready. Any mistake shows up later as a wrong payload or order on the issue port, or as a drift in the stall and fullness flags.

// File: rtl/missq_pkg.sv
`timescale 1ns/1ps
package missq_pkg;
    typedef enum logic {
        PORT_IDLE   = 1'b0,
        PORT_RETURN = 1'b1
    } port_state_e;
endpackage

// File: rtl/missq_wb_sram.sv
`timescale 1ns/1ps
// Single-ported storage for drained payloads: one read or one write per cycle.
module missq_wb_sram #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/missq_rs.sv
`timescale 1ns/1ps
// Reservation-station slots: dispatch, wake on fill, issue, drain pick.
module missq_rs #(
    parameter int RS_DEPTH = 4,
    parameter int TAG_W    = 2,
    parameter int PAY_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_we,
    input  logic             disp_dep,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic [PAY_W-1:0] disp_pay,
    input  logic             ins_we,
    input  logic [PAY_W-1:0] ins_pay,
    input  logic             fill_valid,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             ev_go,
    output logic             iss_valid,
    output logic [PAY_W-1:0] iss_pay,
    output logic             rs_full,
    output logic             ev_ok,
    output logic [TAG_W-1:0] ev_tag,
    output logic [PAY_W-1:0] ev_pay
);
    localparam int IDX_W = (RS_DEPTH > 1) ? $clog2(RS_DEPTH) : 1;

    logic [RS_DEPTH-1:0] vld_q, wt_q;
    logic [TAG_W-1:0]    tag_q [RS_DEPTH];
    logic [PAY_W-1:0]    pay_q [RS_DEPTH];

    logic [IDX_W-1:0] iss_idx, ev_idx, free_idx;
    logic             slot_we, new_wt;
    logic [PAY_W-1:0] new_pay;

    always_comb begin
        iss_idx   = '0;
        ev_idx    = '0;
        free_idx  = '0;
        iss_valid = 1'b0;
        ev_ok     = 1'b0;
        for (int i = RS_DEPTH - 1; i >= 0; i--) begin
            if (vld_q[i] && !wt_q[i]) begin
                iss_idx   = IDX_W'(i);
                iss_valid = 1'b1;
            end
            if (vld_q[i] && wt_q[i] && !(fill_valid && tag_q[i] == fill_tag)) begin
                ev_idx = IDX_W'(i);
                ev_ok  = 1'b1;
            end
            if (!vld_q[i]) free_idx = IDX_W'(i);
        end
        rs_full = &vld_q;
        iss_pay = pay_q[iss_idx];
        ev_tag  = tag_q[ev_idx];
        ev_pay  = pay_q[ev_idx];
        slot_we = disp_we || ins_we;
        new_wt  = disp_dep && !ins_we && !(fill_valid && disp_tag == fill_tag);
        new_pay = ins_we ? ins_pay : disp_pay;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            wt_q  <= '0;
        end else begin
            for (int i = 0; i < RS_DEPTH; i++) begin
                if (iss_valid && iss_idx == IDX_W'(i)) vld_q[i] <= 1'b0;
                if (ev_go && ev_idx == IDX_W'(i))      vld_q[i] <= 1'b0;
                if (fill_valid && vld_q[i] && wt_q[i] && tag_q[i] == fill_tag)
                    wt_q[i] <= 1'b0;
                if (slot_we && free_idx == IDX_W'(i)) begin
                    vld_q[i] <= 1'b1;
                    wt_q[i]  <= new_wt;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < RS_DEPTH; i++) begin
            if (slot_we && free_idx == IDX_W'(i)) begin
                tag_q[i] <= ins_we ? '0 : disp_tag;
                pay_q[i] <= new_pay;
            end
        end
    end
endmodule

// File: rtl/missq_replay_ctrl.sv
`timescale 1ns/1ps
// Port controller plus side table (valid, tag, age order, released tags).
module missq_replay_ctrl
    import missq_pkg::*;
#(
    parameter int WB_DEPTH = 8,
    parameter int TAG_W    = 2,
    localparam int WIDX_W  = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1,
    localparam int N_TAGS  = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rs_full,
    input  logic              disp_valid,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              ev_ok,
    input  logic [TAG_W-1:0]  ev_tag,
    output logic              rd_go,
    output logic              ev_go,
    output logic              ins_we,
    output logic              disp_stall,
    output logic              wb_full,
    output logic              mem_en,
    output logic              mem_we,
    output logic [WIDX_W-1:0] mem_addr
);
    port_state_e state_q, state_d;

    logic [WB_DEPTH-1:0] svld_q;
    logic [TAG_W-1:0]    stag_q [WB_DEPTH];
    logic [WB_DEPTH-1:0] age_q  [WB_DEPTH];   // age_q[i][j]: slot i older than slot j
    logic [N_TAGS-1:0]   rel_q, rel_d;

    logic [WB_DEPTH-1:0] cand;
    logic [WIDX_W-1:0]   rd_idx, wr_idx;
    logic                rd_any;
    logic [WB_DEPTH-1:0] va;
    logic [TAG_W-1:0]    ta [WB_DEPTH];
    logic [N_TAGS-1:0]   present;

    // Oldest released entry and lowest free slot.
    always_comb begin
        rd_idx = '0;
        rd_any = 1'b0;
        wr_idx = '0;
        for (int i = 0; i < WB_DEPTH; i++)
            cand[i] = svld_q[i] && rel_q[stag_q[i]];
        for (int i = WB_DEPTH - 1; i >= 0; i--) begin
            logic older;
            older = 1'b0;
            for (int j = 0; j < WB_DEPTH; j++)
                if (j != i && cand[j] && age_q[j][i]) older = 1'b1;
            if (cand[i] && !older) begin
                rd_idx = WIDX_W'(i);
                rd_any = 1'b1;
            end
            if (!svld_q[i]) wr_idx = WIDX_W'(i);
        end
        wb_full = &svld_q;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: launch read, stay idle, insert done.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE:   state_d = (rd_any && !rs_full) ? PORT_RETURN : PORT_IDLE;
            PORT_RETURN: state_d = PORT_IDLE;
            default:     state_d = PORT_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        rd_go      = 1'b0;
        ev_go      = 1'b0;
        ins_we     = 1'b0;
        disp_stall = 1'b1;
        unique case (state_q)
            PORT_IDLE: begin
                rd_go      = rd_any && !rs_full;
                ev_go      = !rd_go && rs_full && disp_valid && !wb_full && ev_ok;
                disp_stall = rs_full || rd_go;
            end
            PORT_RETURN: begin
                ins_we     = 1'b1;
                disp_stall = 1'b1;
            end
            default: ;
        endcase
        mem_en   = rd_go || ev_go;
        mem_we   = ev_go;
        mem_addr = ev_go ? wr_idx : rd_idx;
    end

    // Released-tag set: a tag stays released while entries of it remain.
    always_comb begin
        present = '0;
        for (int i = 0; i < WB_DEPTH; i++) begin
            va[i] = (svld_q[i] && !(rd_go && rd_idx == WIDX_W'(i)))
                    || (ev_go && wr_idx == WIDX_W'(i));
            ta[i] = (ev_go && wr_idx == WIDX_W'(i)) ? ev_tag : stag_q[i];
        end
        for (int t = 0; t < N_TAGS; t++) begin
            for (int i = 0; i < WB_DEPTH; i++)
                if (va[i] && ta[i] == TAG_W'(t)) present[t] = 1'b1;
            rel_d[t] = (rel_q[t] || (fill_valid && fill_tag == TAG_W'(t))) && present[t];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svld_q <= '0;
            rel_q  <= '0;
        end else begin
            rel_q <= rel_d;
            if (rd_go) svld_q[rd_idx] <= 1'b0;
            if (ev_go) svld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ev_go) begin
            stag_q[wr_idx] <= ev_tag;
            for (int j = 0; j < WB_DEPTH; j++) begin
                age_q[wr_idx][j] <= 1'b0;
                age_q[j][wr_idx] <= (j != int'(wr_idx));
            end
        end
    end
endmodule

// File: rtl/missq_replay.sv
`timescale 1ns/1ps
module missq_replay #(
    parameter int RS_DEPTH = 4,
    parameter int WB_DEPTH = 8,
    parameter int TAG_W    = 2,
    parameter int PAY_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic             disp_dep,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic [PAY_W-1:0] disp_pay,
    output logic             disp_stall,
    output logic             iss_valid,
    output logic [PAY_W-1:0] iss_pay,
    input  logic             fill_valid,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             rs_full,
    output logic             wb_full
);
    localparam int WIDX_W = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;

    logic              rd_go, ev_go, ins_we, ev_ok, disp_we;
    logic              mem_en, mem_we;
    logic [WIDX_W-1:0] mem_addr;
    logic [TAG_W-1:0]  ev_tag;
    logic [PAY_W-1:0]  ev_pay, rd_pay;

    assign disp_we = disp_valid && !disp_stall;

    missq_rs #(.RS_DEPTH(RS_DEPTH), .TAG_W(TAG_W), .PAY_W(PAY_W)) u_rs (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_we    (disp_we),
        .disp_dep   (disp_dep),
        .disp_tag   (disp_tag),
        .disp_pay   (disp_pay),
        .ins_we     (ins_we),
        .ins_pay    (rd_pay),
        .fill_valid (fill_valid),
        .fill_tag   (fill_tag),
        .ev_go      (ev_go),
        .iss_valid  (iss_valid),
        .iss_pay    (iss_pay),
        .rs_full    (rs_full),
        .ev_ok      (ev_ok),
        .ev_tag     (ev_tag),
        .ev_pay     (ev_pay)
    );

    missq_replay_ctrl #(.WB_DEPTH(WB_DEPTH), .TAG_W(TAG_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rs_full    (rs_full),
        .disp_valid (disp_valid),
        .fill_valid (fill_valid),
        .fill_tag   (fill_tag),
        .ev_ok      (ev_ok),
        .ev_tag     (ev_tag),
        .rd_go      (rd_go),
        .ev_go      (ev_go),
        .ins_we     (ins_we),
        .disp_stall (disp_stall),
        .wb_full    (wb_full),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr)
    );

    missq_wb_sram #(.DEPTH(WB_DEPTH), .DATA_W(PAY_W)) u_wb (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (ev_pay),
        .rdata (rd_pay)
    );
endmodule

// File: rtl/missq_replay_chk.sv
`timescale 1ns/1ps
module missq_replay_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_go,
    input logic ev_go,
    input logic ins_we,
    input logic rs_full,
    input logic wb_full
);
    AST_INSERT_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> ins_we); // R7
    AST_INSERT_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ins_we |-> $past(rd_go)); // R7
    AST_READ_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> !rs_full); // R6
    AST_DRAIN_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_go |=> !rs_full); // R4
    AST_WB_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_full && !rd_go) |=> wb_full); // R5
endmodule

bind missq_replay missq_replay_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_go   (rd_go),
    .ev_go   (ev_go),
    .ins_we  (ins_we),
    .rs_full (rs_full),
    .wb_full (wb_full)
);

// File: tb/missq_replay_tb.sv
`timescale 1ns/1ps
module missq_replay_tb;
    localparam int RS = 4;
    localparam int WB = 8;
    localparam int TW = 2;
    localparam int PW = 8;
    localparam int NT = 1 << TW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dv = 1'b0, dep = 1'b0, fv = 1'b0;
    logic [TW-1:0] dtag = '0, ftag = '0;
    logic [PW-1:0] dpay = '0;
    logic          disp_stall, iss_valid, rs_full, wb_full;
    logic [PW-1:0] iss_pay;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    missq_replay #(.RS_DEPTH(RS), .WB_DEPTH(WB), .TAG_W(TW), .PAY_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(dv), .disp_dep(dep), .disp_tag(dtag), .disp_pay(dpay),
        .disp_stall(disp_stall), .iss_valid(iss_valid), .iss_pay(iss_pay),
        .fill_valid(fv), .fill_tag(ftag), .rs_full(rs_full), .wb_full(wb_full)
    );

    // Reference model, built from the requirements.
    bit m_v [RS];
    bit m_w [RS];
    int m_tag [RS];
    int m_pay [RS];
    int q_tag [$];
    int q_pay [$];
    bit m_rel [NT];
    bit m_ret;
    int m_retpay;

    function automatic int f_iss();
        for (int i = 0; i < RS; i++) if (m_v[i] && !m_w[i]) return i;
        return -1;
    endfunction
    function automatic bit f_full();
        for (int i = 0; i < RS; i++) if (!m_v[i]) return 1'b0;
        return 1'b1;
    endfunction
    function automatic int f_free();
        for (int i = 0; i < RS; i++) if (!m_v[i]) return i;
        return -1;
    endfunction
    function automatic int f_cand();
        for (int k = 0; k < q_tag.size(); k++) if (m_rel[q_tag[k]]) return k;
        return -1;
    endfunction
    function automatic bit f_read();
        return !m_ret && f_cand() >= 0 && !f_full();
    endfunction
    function automatic bit f_stall();
        return f_full() || m_ret || f_read();
    endfunction

    task automatic model_reset();
        for (int i = 0; i < RS; i++) begin m_v[i] = 0; m_w[i] = 0; end
        for (int t = 0; t < NT; t++) m_rel[t] = 0;
        q_tag.delete(); q_pay.delete();
        m_ret = 0; m_retpay = 0;
    endtask

    task automatic model_step();
        int  iss, cand, evi, fr, t_in, f_t;
        bit  rd, stl, ev, full, ret_now;
        int  retpay_now;
        t_in = int'(dtag);
        f_t  = int'(ftag);
        iss  = f_iss();
        full = f_full();
        cand = f_cand();
        rd   = f_read();
        stl  = f_stall();
        fr   = f_free();
        evi  = -1;
        for (int i = RS - 1; i >= 0; i--)
            if (m_v[i] && m_w[i] && !(fv && m_tag[i] == f_t)) evi = i;
        ev = !m_ret && !rd && full && dv && (q_tag.size() < WB) && evi >= 0;
        ret_now = m_ret;
        retpay_now = m_retpay;
        if (iss >= 0) m_v[iss] = 0;
        if (ev) begin
            q_tag.push_back(m_tag[evi]);
            q_pay.push_back(m_pay[evi]);
            m_v[evi] = 0;
        end
        if (fv)
            for (int i = 0; i < RS; i++)
                if (m_v[i] && m_w[i] && m_tag[i] == f_t) m_w[i] = 0;
        if (dv && !stl) begin
            m_v[fr] = 1; m_w[fr] = dep && !(fv && f_t == t_in);
            m_tag[fr] = t_in; m_pay[fr] = int'(dpay);
        end
        if (ret_now) begin
            m_v[fr] = 1; m_w[fr] = 0; m_tag[fr] = 0; m_pay[fr] = retpay_now;
            m_ret = 0;
        end
        if (rd) begin
            m_retpay = q_pay[cand];
            q_tag.delete(cand); q_pay.delete(cand);
            m_ret = 1;
        end
        for (int t = 0; t < NT; t++) begin
            bit pres;
            pres = 0;
            foreach (q_tag[k]) if (q_tag[k] == t) pres = 1;
            m_rel[t] = (m_rel[t] || (fv && f_t == t)) && pres;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    task automatic chk(string req, string ph, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] %s actual %0h expected %0h", req, ph, what, act, exp);
        end
    endtask

    task automatic compare(string ph);
        int ei;
        ei = f_iss();
        chk("R1", ph, "iss_valid", int'(iss_valid), (ei >= 0) ? 1 : 0);
        if (ei >= 0 && iss_valid) chk("R1", ph, "iss_pay", int'(iss_pay), m_pay[ei]);
        chk("R3", ph, "disp_stall", int'(disp_stall), int'(f_stall()));
        chk("R3", ph, "rs_full", int'(rs_full), int'(f_full()));
        chk("R5", ph, "wb_full", int'(wb_full), (q_tag.size() == WB) ? 1 : 0);
    endtask

    task automatic step(bit v, bit d, int t, int p, bit f, int ft, string ph);
        @(negedge clk);
        compare(ph);
        dv = v; dep = d; dtag = TW'(t); dpay = PW'(p);
        fv = f; ftag = TW'(ft);
    endtask

    task automatic idle(int n, string ph);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, ph);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R9 reset state");
        step(1, 0, 0, 8'h11, 0, 0, "R1 ready dispatch");
        idle(2, "R1 ready issue");
        step(0, 0, 0, 0, 1, 3, "R8 unmatched fill");
        step(1, 1, 1, 8'h21, 0, 0, "R2 dependent dispatch");
        idle(2, "R2 waiting");
        step(0, 0, 0, 0, 1, 1, "R2 wake");
        idle(2, "R2 issue after wake");
        for (int i = 0; i < 4; i++) step(1, 1, 2, 8'h40 + i, 0, 0, "R4 fill array");
        for (int i = 0; i < 6; i++) step(1, 1, 3, 8'h50 + i, 0, 0, "R4 drain");
        for (int i = 0; i < 20; i++) step(1, 1, 3, 8'h60 + i, 0, 0, "R5 buffer full");
        step(0, 0, 0, 0, 1, 2, "R6 release tag");
        idle(12, "R7 replay return");
        step(0, 0, 0, 0, 1, 3, "R10 release second tag");
        idle(30, "R10 drained order");
        step(0, 0, 0, 0, 1, 1, "R8 stale fill");
        idle(4, "R8 stale fill");
        for (int n = 0; n < 3000; n++) begin
            bit v, d, f;
            int t, p, ft;
            v  = ($urandom % 4) != 0;
            d  = ($urandom % 2) != 0;
            t  = $urandom % NT;
            p  = $urandom % 256;
            f  = ($urandom % 6) == 0;
            ft = $urandom % NT;
            step(v, d, t, p, f, ft, "R6 random traffic");
        end
        for (int t = 0; t < NT; t++) step(0, 0, 0, 0, 1, t, "R7 final drain");
        idle(40, "R7 final drain");
        @(negedge clk);
        compare("R9 end");
        summary();
        $finish;
    end
endmodule